// File: doc/BRIEF.md
# Boundary-scan test access port controller

This block is the serial test port of a device. It follows the 16-state test port state machine on the rising edge of the test clock, holds a 5-bit instruction, and uses that instruction to pick which data path sits between the serial input and the serial output. There are three paths: a one-bit bypass stage, a 32-bit identification register, and an external boundary chain whose scan-out comes back into the block. The boundary cells themselves live outside this block.

The decoded instruction also sets how the device pins behave. The pins can be handed to the boundary update stage, forced to high impedance, or left in normal operation. The block also produces the capture, shift and update strobes for the boundary chain. Serial output data changes on the falling edge of the test clock and is qualified by an output-enable, which the pad uses to tri-state the line.

Top module: `tap_unit`

## Requirements
- R1: While `trst_n` is low, asynchronously and with no clock edge needed, the controller is in Test-Logic-Reset. The active instruction is IDCODE (00100), `tdo_oe` is 0, and `pin_drive_bnd` and `pin_disable` are both 0.
- R2: From any state, five rising clock edges with `tms` high bring the controller to Test-Logic-Reset. While it is in that state the active instruction is IDCODE.
- R3: In Capture-IR the instruction shift stage loads 00001. Bits [1:0] are 01 and the upper bits are zero. In Shift-IR it shifts out least significant bit first.
- R4: The identification path captures, from bit 31 down to bit 0, a 4-bit version, a 16-bit part number, the 11-bit manufacturer code 00000101111, and a 1. It shifts out bit 0 first. With the default parameters the value is 32'h12A5C05F.
- R5: BYPASS (11111), HIGHZ (01110), CLAMP (01111) and USERCODE (00011) select a one-bit path that captures 0. After N shifts, output bit i equals input bit i-1, and output bit 0 is 0.
- R6: EXTEST (00000), SAMPLE (00001) and INTEST (00010) route `bnd_so` to `tdo`. Under these instructions only, `bnd_capture`, `bnd_shift` and `bnd_update` are high in Capture-DR, Shift-DR and Update-DR respectively.
- R7: HIGHZ sets `pin_disable` to 1 and `pin_drive_bnd` to 0.
- R8: CLAMP, EXTEST and INTEST set `pin_drive_bnd` to 1 with `pin_disable` at 0. SAMPLE leaves both at 0.
- R9: `tdo` and `tdo_oe` change only on the falling clock edge. `tdo_oe` is 1 only after a falling edge that sees the controller in Shift-IR or Shift-DR.
- R10: The active instruction and the pin controls change only when the controller leaves Update-IR or enters reset. Shifting a new opcode leaves them unchanged.
- R11: The private opcode 10000 and any unlisted opcode select the bypass path and leave both pin controls at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in |
| bnd_so | input | 1 | Scan-out of the external boundary chain |
| tdo | output | 1 | Serial data out, falling-edge register |
| tdo_oe | output | 1 | Output-enable for `tdo` |
| bnd_capture | output | 1 | Boundary capture strobe |
| bnd_shift | output | 1 | Boundary shift strobe |
| bnd_update | output | 1 | Boundary update strobe |
| pin_drive_bnd | output | 1 | Pins take values from the boundary update stage |
| pin_disable | output | 1 | All device pins to high impedance |

## Verification
A behavioural model follows the state and the instruction from the `tms` and `tdi` streams. On every falling edge it compares all strobes, pin controls and the output-enable, so a wrong transition or a wrong decode is caught in the cycle it happens. Data reads use three kinds of pattern. An all-zero input over the identification path shows the captured constant and its bit order. Alternating input over the one-bit path shows the path length. A pattern on the chain return that differs from the `tdi` pattern shows that the boundary path is the one selected. Every listed opcode, the private opcode and an unlisted opcode are each loaded. While each is loaded the pin controls are checked mid-shift, which separates a held instruction from a stage that leaks through. Reset is entered both through the five-cycle `tms` sequence and through the asynchronous pin in the middle of a mode.

// File: rtl/tap_pkg.sv
package tap_pkg;
  localparam int IR_W = 5;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_DR_SEL, ST_DR_CAP, ST_DR_SHIFT, ST_DR_EX1, ST_DR_PAUSE, ST_DR_EX2, ST_DR_UPD,
    ST_IR_SEL, ST_IR_CAP, ST_IR_SHIFT, ST_IR_EX1, ST_IR_PAUSE, ST_IR_EX2, ST_IR_UPD
  } tap_state_e;

  typedef enum logic [1:0] { PATH_BYP, PATH_ID, PATH_BND } dr_path_e;

  localparam logic [IR_W-1:0] OP_EXTEST   = 5'b00000;
  localparam logic [IR_W-1:0] OP_SAMPLE   = 5'b00001;
  localparam logic [IR_W-1:0] OP_INTEST   = 5'b00010;
  localparam logic [IR_W-1:0] OP_USERCODE = 5'b00011;
  localparam logic [IR_W-1:0] OP_IDCODE   = 5'b00100;
  localparam logic [IR_W-1:0] OP_HIGHZ    = 5'b01110;
  localparam logic [IR_W-1:0] OP_CLAMP    = 5'b01111;
  localparam logic [IR_W-1:0] OP_PROBE    = 5'b10000;
  localparam logic [IR_W-1:0] OP_BYPASS   = 5'b11111;

  // value forced into the instruction shift stage in Capture-IR
  localparam logic [IR_W-1:0] IR_CAPTURE = {{(IR_W-2){1'b0}}, 2'b01};

  function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
    case (s)
      ST_RESET:    return m ? ST_RESET  : ST_IDLE;
      ST_IDLE:     return m ? ST_DR_SEL : ST_IDLE;
      ST_DR_SEL:   return m ? ST_IR_SEL : ST_DR_CAP;
      ST_DR_CAP:   return m ? ST_DR_EX1 : ST_DR_SHIFT;
      ST_DR_SHIFT: return m ? ST_DR_EX1 : ST_DR_SHIFT;
      ST_DR_EX1:   return m ? ST_DR_UPD : ST_DR_PAUSE;
      ST_DR_PAUSE: return m ? ST_DR_EX2 : ST_DR_PAUSE;
      ST_DR_EX2:   return m ? ST_DR_UPD : ST_DR_SHIFT;
      ST_DR_UPD:   return m ? ST_DR_SEL : ST_IDLE;
      ST_IR_SEL:   return m ? ST_RESET  : ST_IR_CAP;
      ST_IR_CAP:   return m ? ST_IR_EX1 : ST_IR_SHIFT;
      ST_IR_SHIFT: return m ? ST_IR_EX1 : ST_IR_SHIFT;
      ST_IR_EX1:   return m ? ST_IR_UPD : ST_IR_PAUSE;
      ST_IR_PAUSE: return m ? ST_IR_EX2 : ST_IR_PAUSE;
      ST_IR_EX2:   return m ? ST_IR_UPD : ST_IR_SHIFT;
      ST_IR_UPD:   return m ? ST_DR_SEL : ST_IDLE;
      default:     return ST_RESET;
    endcase
  endfunction
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state_o
);
  tap_state_e state_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state_q <= ST_RESET;
    else         state_q <= tap_next(state_q, tms);
  end

  assign state_o = state_q;

  // R2
  tms_reset_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
      |=> (state_q == ST_RESET));
endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_pkg::*;
(
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tdi,
  input  tap_state_e      state,
  output logic [IR_W-1:0] ir_o,
  output logic            ir_so
);
  logic [IR_W-1:0] sh_q;
  logic [IR_W-1:0] ir_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      sh_q <= IR_CAPTURE;
    end else if (state == ST_IR_CAP) begin
      sh_q <= IR_CAPTURE;
    end else if (state == ST_IR_SHIFT) begin
      sh_q <= {tdi, sh_q[IR_W-1:1]};
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                 ir_q <= OP_IDCODE;
    else if (state == ST_RESET)  ir_q <= OP_IDCODE;
    else if (state == ST_IR_UPD) ir_q <= sh_q;
  end

  // reset state overrides the held opcode at once
  assign ir_o  = (state == ST_RESET) ? OP_IDCODE : ir_q;
  assign ir_so = sh_q[0];

  // R10
  ir_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state != ST_IR_UPD && state != ST_RESET) |=> $stable(ir_q));

  // R3
  ir_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_IR_CAP) |=> (sh_q[1:0] == 2'b01));
endmodule

// File: rtl/tap_decode.sv
module tap_decode
  import tap_pkg::*;
(
  input  logic [IR_W-1:0] ir,
  output dr_path_e        path,
  output logic            drive_bnd,
  output logic            pins_off,
  output logic            bnd_on
);
  always_comb begin
    path      = PATH_BYP;
    drive_bnd = 1'b0;
    pins_off  = 1'b0;
    bnd_on    = 1'b0;
    case (ir)
      OP_EXTEST: begin path = PATH_BND; drive_bnd = 1'b1; bnd_on = 1'b1; end
      OP_SAMPLE: begin path = PATH_BND; bnd_on = 1'b1; end
      OP_INTEST: begin path = PATH_BND; drive_bnd = 1'b1; bnd_on = 1'b1; end
      OP_IDCODE: path = PATH_ID;
      OP_HIGHZ:  pins_off = 1'b1;
      OP_CLAMP:  drive_bnd = 1'b1;
      OP_USERCODE, OP_PROBE, OP_BYPASS: path = PATH_BYP;
      default:   path = PATH_BYP;
    endcase
  end
endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import tap_pkg::*;
#(
  parameter int              ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = '1
) (
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tdi,
  input  tap_state_e state,
  input  dr_path_e   path,
  input  logic       bnd_so,
  output logic       dr_so
);
  logic            byp_q;
  logic [ID_W-1:0] id_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      byp_q <= 1'b0;
      id_q  <= ID_VALUE;
    end else if (state == ST_DR_CAP) begin
      byp_q <= 1'b0;
      id_q  <= ID_VALUE;
    end else if (state == ST_DR_SHIFT) begin
      byp_q <= tdi;
      id_q  <= {tdi, id_q[ID_W-1:1]};
    end
  end

  always_comb begin
    case (path)
      PATH_ID:  dr_so = id_q[0];
      PATH_BND: dr_so = bnd_so;
      default:  dr_so = byp_q;
    endcase
  end
endmodule

// File: rtl/tap_unit.sv
module tap_unit
  import tap_pkg::*;
#(
  parameter int VER_W  = 4,
  parameter int PART_W = 16,
  parameter int MFR_W  = 11,
  parameter logic [VER_W-1:0]  ID_VERSION = 4'h1,
  parameter logic [PART_W-1:0] ID_PART    = 16'h2A5C,
  parameter logic [MFR_W-1:0]  ID_MFR     = 11'b00000101111
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tms,
  input  logic tdi,
  input  logic bnd_so,
  output logic tdo,
  output logic tdo_oe,
  output logic bnd_capture,
  output logic bnd_shift,
  output logic bnd_update,
  output logic pin_drive_bnd,
  output logic pin_disable
);
  localparam int              ID_W     = VER_W + PART_W + MFR_W + 1;
  localparam logic [ID_W-1:0] ID_VALUE = {ID_VERSION, ID_PART, ID_MFR, 1'b1};

  tap_state_e      state;
  logic [IR_W-1:0] ir;
  logic            ir_so;
  logic            dr_so;
  dr_path_e        path;
  logic            drive_bnd;
  logic            pins_off;
  logic            bnd_on;
  logic            tdo_q;
  logic            oe_q;

  tap_fsm u_fsm (.tck(tck), .trst_n(trst_n), .tms(tms), .state_o(state));

  tap_ir u_ir (.tck(tck), .trst_n(trst_n), .tdi(tdi), .state(state),
               .ir_o(ir), .ir_so(ir_so));

  tap_decode u_dec (.ir(ir), .path(path), .drive_bnd(drive_bnd),
                    .pins_off(pins_off), .bnd_on(bnd_on));

  tap_dr #(.ID_W(ID_W), .ID_VALUE(ID_VALUE)) u_dr (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .state(state), .path(path),
    .bnd_so(bnd_so), .dr_so(dr_so));

  // output stage on the falling edge, half a cycle after the shift
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      tdo_q <= (state == ST_IR_SHIFT) ? ir_so : dr_so;
      oe_q  <= (state == ST_IR_SHIFT) || (state == ST_DR_SHIFT);
    end
  end

  assign tdo           = tdo_q;
  assign tdo_oe        = oe_q;
  assign bnd_capture   = bnd_on && (state == ST_DR_CAP);
  assign bnd_shift     = bnd_on && (state == ST_DR_SHIFT);
  assign bnd_update    = bnd_on && (state == ST_DR_UPD);
  assign pin_drive_bnd = drive_bnd;
  assign pin_disable   = pins_off;

  // R9
  oe_window_chk: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe == ((state == ST_IR_SHIFT) || (state == ST_DR_SHIFT)));

  // R6
  bnd_update_exit_chk: assert property (@(posedge tck) disable iff (!trst_n)
    bnd_update |=> (state == ST_IDLE || state == ST_DR_SEL));

  // R8
  clamp_pins_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (ir == OP_CLAMP) |-> (pin_drive_bnd && !pin_disable));

  // R7
  highz_pins_chk: assert property (@(posedge tck) disable iff (!trst_n)
    pin_disable |-> !pin_drive_bnd);
endmodule

// File: tb/test_tap_unit.sv
module test_tap_unit;
  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0, bnd_so = 1'b0;
  logic tdo, tdo_oe, bnd_capture, bnd_shift, bnd_update, pin_drive_bnd, pin_disable;

  tap_unit i_tap_unit (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .bnd_so(bnd_so),
    .tdo(tdo), .tdo_oe(tdo_oe), .bnd_capture(bnd_capture), .bnd_shift(bnd_shift),
    .bnd_update(bnd_update), .pin_drive_bnd(pin_drive_bnd), .pin_disable(pin_disable));

  always #4 tck = ~tck;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  localparam logic [31:0] EXP_ID = {4'h1, 16'h2A5C, 11'b00000101111, 1'b1};

  // behavioural model: integer state codes
  localparam int S_TLR = 0, S_RTI = 1, S_SDR = 2, S_CDR = 3, S_SHDR = 4, S_E1DR = 5,
                 S_PDR = 6, S_E2DR = 7, S_UDR = 8, S_SIR = 9, S_CIR = 10, S_SHIR = 11,
                 S_E1IR = 12, S_PIR = 13, S_E2IR = 14, S_UIR = 15;
  int         m_state = S_TLR;
  logic [4:0] m_ir = 5'b00100;
  logic [4:0] m_sh = 5'b00001;
  logic       m_oe = 1'b0;

  function automatic int m_next(int s, logic t);
    case (s)
      S_TLR:  return t ? S_TLR : S_RTI;
      S_RTI:  return t ? S_SDR : S_RTI;
      S_SDR:  return t ? S_SIR : S_CDR;
      S_CDR, S_SHDR: return t ? S_E1DR : S_SHDR;
      S_E1DR: return t ? S_UDR : S_PDR;
      S_PDR:  return t ? S_E2DR : S_PDR;
      S_E2DR: return t ? S_UDR : S_SHDR;
      S_SIR:  return t ? S_TLR : S_CIR;
      S_CIR, S_SHIR: return t ? S_E1IR : S_SHIR;
      S_E1IR: return t ? S_UIR : S_PIR;
      S_PIR:  return t ? S_E2IR : S_PIR;
      S_E2IR: return t ? S_UIR : S_SHIR;
      default: return t ? S_SDR : S_RTI; // both update states
    endcase
  endfunction

  always @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      m_state <= S_TLR; m_ir <= 5'b00100; m_sh <= 5'b00001;
    end else begin
      if (m_state == S_CIR) m_sh <= 5'b00001;
      else if (m_state == S_SHIR) m_sh <= {tdi, m_sh[4:1]};
      if (m_state == S_UIR) m_ir <= m_sh;
      else if (m_state == S_TLR) m_ir <= 5'b00100;
      m_state <= m_next(m_state, tms);
    end
  end

  always @(negedge tck or negedge trst_n) begin
    if (!trst_n) m_oe <= 1'b0;
    else m_oe <= (m_state == S_SHIR) || (m_state == S_SHDR);
  end

  // per-clock comparison of the mode outputs
  always @(negedge tck) begin
    #1;
    if (trst_n) begin
      logic [4:0] act;
      logic bnd;
      logic [5:0] exp_v, got_v;
      act = (m_state == S_TLR) ? 5'b00100 : m_ir;
      bnd = (act <= 5'b00010);
      exp_v = {bnd && m_state == S_CDR, bnd && m_state == S_SHDR, bnd && m_state == S_UDR,
               (act == 5'b00000 || act == 5'b00010 || act == 5'b01111),
               (act == 5'b01110), m_oe};
      got_v = {bnd_capture, bnd_shift, bnd_update, pin_drive_bnd, pin_disable, tdo_oe};
      checks++;
      if (got_v !== exp_v) begin
        errors++;
        $display("FAIL R6/R7/R8/R9 model compare: actual %b expected %b", got_v, exp_v);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic m, input logic d, output logic o);
    tms = m; tdi = d;
    #1;
    o = tdo;
    @(negedge tck); #1;
  endtask

  // from Run-Test/Idle back to Run-Test/Idle
  task automatic shift_dr(input int n, input logic [31:0] din, input logic [31:0] bsr,
                          output logic [31:0] dout);
    logic b;
    dout = '0;
    tick(1, 0, b); tick(0, 0, b);
    bnd_so = bsr[0];
    tick(0, 0, b);
    for (int i = 0; i < n; i++) begin
      bnd_so = (i + 1 < 32) ? bsr[(i + 1) % 32] : 1'b0;
      tick(i == n - 1, din[i], b);
      dout[i] = b;
    end
    tick(1, 0, b); tick(0, 0, b);
  endtask

  task automatic load_ir(input logic [4:0] op, output logic [4:0] cap);
    logic b;
    logic drv0, off0;
    drv0 = pin_drive_bnd; off0 = pin_disable;
    cap = '0;
    tick(1, 0, b); tick(1, 0, b); tick(0, 0, b); tick(0, 0, b);
    for (int i = 0; i < 5; i++) begin
      tick(i == 4, op[i], b);
      cap[i] = b;
      // R10: pin controls hold while the new opcode is shifted
      chk("R10 hold during shift", {30'd0, pin_drive_bnd, pin_disable}, {30'd0, drv0, off0});
    end
    tick(1, 0, b); tick(0, 0, b);
  endtask

  task automatic check_bypass(input string tag);
    logic [31:0] o;
    shift_dr(8, 32'h000000B3, 32'h0000005A, o);
    chk(tag, o[7:0], 32'h00000066); // {din[6:0], 0}
  endtask

  initial begin : watchdog
    while (cycles < 20000) begin @(posedge tck); cycles++; end
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [31:0] o;
    logic [4:0] cap;
    logic b;
    repeat (3) @(negedge tck);
    #1;
    // R1: reset state at the ports
    chk("R1 oe in reset", {31'd0, tdo_oe}, 32'd0);
    chk("R1 pins in reset", {30'd0, pin_drive_bnd, pin_disable}, 32'd0);
    trst_n = 1'b1;
    tick(0, 0, b);
    // R1 R4: identification selected after reset
    shift_dr(32, 32'd0, 32'd0, o);
    chk("R4 id value", o, EXP_ID);

    // R3 R5: bypass
    load_ir(5'b11111, cap);
    chk("R3 ir capture", {27'd0, cap}, 32'd1);
    check_bypass("R5 bypass opcode");

    // R7 HIGHZ
    load_ir(5'b01110, cap);
    chk("R7 highz pins", {30'd0, pin_drive_bnd, pin_disable}, 32'd1);
    check_bypass("R5 highz path");

    // R8 CLAMP
    load_ir(5'b01111, cap);
    chk("R8 clamp pins", {30'd0, pin_drive_bnd, pin_disable}, 32'd2);
    check_bypass("R5 clamp path");

    // R6 R8 EXTEST through boundary chain
    load_ir(5'b00000, cap);
    chk("R8 extest pins", {30'd0, pin_drive_bnd, pin_disable}, 32'd2);
    shift_dr(6, 32'h00000015, 32'h0000002C, o);
    chk("R6 extest chain", o[5:0], 32'h0000002C);

    // R6 R8 SAMPLE
    load_ir(5'b00001, cap);
    chk("R8 sample pins", {30'd0, pin_drive_bnd, pin_disable}, 32'd0);
    shift_dr(6, 32'h0000003F, 32'h00000013, o);
    chk("R6 sample chain", o[5:0], 32'h00000013);

    // R8 INTEST
    load_ir(5'b00010, cap);
    chk("R8 intest pins", {30'd0, pin_drive_bnd, pin_disable}, 32'd2);

    // R5 USERCODE, R11 private and unlisted
    load_ir(5'b00011, cap);
    check_bypass("R5 usercode path");
    load_ir(5'b10000, cap);
    chk("R11 private pins", {30'd0, pin_drive_bnd, pin_disable}, 32'd0);
    check_bypass("R11 private path");
    load_ir(5'b10101, cap);
    chk("R11 unlisted pins", {30'd0, pin_drive_bnd, pin_disable}, 32'd0);
    check_bypass("R11 unlisted path");

    // R2: five tms-high cycles from Shift-DR
    load_ir(5'b00000, cap);
    tick(1, 0, b); tick(0, 0, b); tick(0, 0, b);
    chk("R9 oe in shift", {31'd0, tdo_oe}, 32'd1);
    for (int i = 0; i < 5; i++) tick(1, 0, b);
    chk("R2 pins after tms reset", {30'd0, pin_drive_bnd, pin_disable}, 32'd0);
    chk("R9 oe outside shift", {31'd0, tdo_oe}, 32'd0);
    tick(0, 0, b);
    shift_dr(32, 32'd0, 32'd0, o);
    chk("R2 id after tms reset", o, EXP_ID);

    // R1: asynchronous reset in the middle of HIGHZ
    load_ir(5'b01110, cap);
    chk("R7 highz again", {30'd0, pin_drive_bnd, pin_disable}, 32'd1);
    #1 trst_n = 1'b0;
    #1;
    chk("R1 async pins", {30'd0, pin_drive_bnd, pin_disable}, 32'd0);
    @(negedge tck); #1;
    trst_n = 1'b1;
    tick(0, 0, b);
    shift_dr(32, 32'd0, 32'd0, o);
    chk("R1 id after async reset", o, EXP_ID);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule